// File: doc/BRIEF.md
# Prioritized Interrupt Vector Selector

This block sits beside a CPU core and decides which interrupt or trap is serviced next. Peripherals and pins present level request flags, and each flag has a local enable where one exists. Every request is then qualified by one of two global mask bits from the CPU status word, or by neither. The block always knows whether some request survives its masks and shows that on a combinational `pending` output.

When the CPU signals that the current instruction is finishing (`insn_boundary`), the block picks the surviving request with the highest vector address. On the next cycle it presents that request's 16-bit vector address, a one-cycle `take` strobe, and commands that set the global masks. Software-interrupt and illegal-opcode events arrive as single-cycle pulses. The block holds them until they are serviced. Register stacking, vector fetch and the peripheral flag logic are outside the block.

Top module: `irq_vector_unit`

## Requirements
- R1: While `rst` is high, `vector_addr` reads 0xFFFE and `take`, `set_i`, `set_x` are low, whatever requests or boundary strobes are present. The same values hold in the first cycle after `rst` falls.
- R2: Source index k has vector 0xFFD6 + 2k. The index order is: SCI = 0, `periph_req[j]` = j+1 (j = 0..12, bit 0 being the serial-peripheral transfer and bit 12 the real-time tick), IRQ pin = 14, XIRQ pin = 15, software interrupt = 16, illegal opcode = 17, COP failure = 18, clock-monitor failure = 19. When several requests survive, the highest vector address wins.
- R3: When `i_mask` is 1, sources 0 to 14 (SCI through the IRQ pin) are blocked.
- R4: `x_mask` blocks only the XIRQ pin. `i_mask` has no effect on XIRQ.
- R5: Software interrupt, illegal opcode, COP failure and clock-monitor failure ignore both `i_mask` and `x_mask`.
- R6: A peripheral request `periph_req[j]` counts only when `periph_en[j]` is 1. The IRQ and XIRQ pins have no local enable.
- R7: The SCI vector is shared by five flags, mapped as follows:
  - `sci_flags[0]` is transmit complete and is enabled by `sci_en[0]`.
  - `sci_flags[1]` is transmit register empty and is enabled by `sci_en[1]`.
  - `sci_flags[2]` is idle line and is enabled by `sci_en[2]`.
  - `sci_flags[3]` is overrun and `sci_flags[4]` is receive full. Both are enabled by `sci_en[3]`.
- R8: COP failure counts only while `cop_disable` is 0. Clock-monitor failure counts only while `clkmon_en` is 1.
- R9: `take` is high exactly in the cycle after a cycle in which `insn_boundary` is high and at least one request survives. Otherwise `take` is low and `vector_addr` keeps its previous value.
- R10: `set_i` is high with every `take`. `set_x` is high only with a `take` of the XIRQ vector 0xFFF4.
- R11: `pending` is high in the same cycle, with no register in between, whenever any request survives its masks.
- R12: A one-cycle pulse on `swi_pulse` or `illop_pulse` is held until it is serviced and is cleared by that service. One pulse gives exactly one `take`.
- R13: On every `take`, `vector_addr` lies within 0xFFD6 to 0xFFFC. Neither the reserved range below 0xFFD6 nor the reset vector is ever issued through `take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the reset source |
| insn_boundary | input | 1 | Current instruction completes this cycle |
| i_mask | input | 1 | Global I mask bit from CPU status |
| x_mask | input | 1 | Global X mask bit from CPU status |
| periph_req | input | 13 | Peripheral request flags, index j maps to source j+1 |
| periph_en | input | 13 | Local enables for `periph_req` |
| sci_flags | input | 5 | SCI sub-source flags |
| sci_en | input | 4 | SCI local enables |
| irq_req | input | 1 | IRQ pin request level |
| xirq_req | input | 1 | XIRQ pin request level |
| swi_pulse | input | 1 | Software interrupt pulse from decoder |
| illop_pulse | input | 1 | Illegal opcode pulse from decoder |
| cop_fail | input | 1 | Watchdog timeout flag |
| cop_disable | input | 1 | Watchdog disable bit |
| clkmon_fail | input | 1 | Clock monitor failure flag |
| clkmon_en | input | 1 | Clock monitor enable bit |
| pending | output | 1 | Some request survives its masks |
| take | output | 1 | One-cycle service strobe |
| set_i | output | 1 | Command to set the I mask |
| set_x | output | 1 | Command to set the X mask |
| vector_addr | output | 16 | Vector address of the serviced source |

## Verification
The bench targets the receive-full flag that shares its enable with overrun. A design that wired it to the idle enable would stay silent or fire under the wrong enable. The bench sets both global masks at once, so a design that let `i_mask` block XIRQ, or let either mask block a trap, would miss a service. It pulses a trap with no boundary and checks that it is serviced later and exactly once; a latch that failed to hold or failed to clear would give zero or two takes. It also holds a request with the boundary low, checks that no service occurs, and checks the priority order with competing requests, which catches a reversed encoder or a shifted vector index.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int unsigned VEC_W       = 16;
  localparam int unsigned SCI_NFLAG   = 5;
  localparam int unsigned SCI_NEN     = 4;
  localparam int unsigned DEF_PERIPH  = 13;
  localparam int unsigned NUM_TRAP    = 2;
  localparam logic [VEC_W-1:0] VEC_BASE  = 16'hFFD6;
  localparam logic [VEC_W-1:0] RESET_VEC = 16'hFFFE;

  // trap latch slots
  localparam int unsigned TRAP_SWI   = 0;
  localparam int unsigned TRAP_ILLOP = 1;
endpackage

// File: rtl/ivu_req_gate.sv
module ivu_req_gate
  import ivu_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = DEF_PERIPH,
  localparam int unsigned NUM_SRC   = NUM_PERIPH + 7
) (
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic [NUM_PERIPH-1:0] periph_en,
  input  logic [SCI_NFLAG-1:0]  sci_flags,
  input  logic [SCI_NEN-1:0]    sci_en,
  input  logic                  irq_req,
  input  logic                  xirq_req,
  input  logic                  swi_req,
  input  logic                  illop_req,
  input  logic                  cop_fail,
  input  logic                  cop_disable,
  input  logic                  clkmon_fail,
  input  logic                  clkmon_en,
  input  logic                  i_mask,
  input  logic                  x_mask,
  output logic [NUM_SRC-1:0]    live
);
  localparam int unsigned IRQ_IDX   = NUM_PERIPH + 1;
  localparam int unsigned XIRQ_IDX  = NUM_PERIPH + 2;
  localparam int unsigned SWI_IDX   = NUM_PERIPH + 3;
  localparam int unsigned ILLOP_IDX = NUM_PERIPH + 4;
  localparam int unsigned COP_IDX   = NUM_PERIPH + 5;
  localparam int unsigned CMF_IDX   = NUM_PERIPH + 6;

  logic [SCI_NFLAG-1:0] sci_en_wide;
  logic                 sci_hit;

  // receive-full and overrun share the receiver enable
  assign sci_en_wide = {sci_en[3], sci_en[3], sci_en[2], sci_en[1], sci_en[0]};
  assign sci_hit     = |(sci_flags & sci_en_wide);
  assign live[0]     = sci_hit & ~i_mask;

  for (genvar j = 0; j < NUM_PERIPH; j++) begin : g_periph
    assign live[j+1] = periph_req[j] & periph_en[j] & ~i_mask;
  end

  assign live[IRQ_IDX]   = irq_req & ~i_mask;
  assign live[XIRQ_IDX]  = xirq_req & ~x_mask;
  assign live[SWI_IDX]   = swi_req;
  assign live[ILLOP_IDX] = illop_req;
  assign live[COP_IDX]   = cop_fail & ~cop_disable;
  assign live[CMF_IDX]   = clkmon_fail & clkmon_en;
endmodule

// File: rtl/ivu_prio_enc.sv
module ivu_prio_enc #(
  parameter int unsigned N  = 20,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  // highest index wins: later iterations overwrite earlier ones
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      if (req[k]) begin
        valid = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/ivu_trap_latch.sv
module ivu_trap_latch #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pulse,
  input  logic [W-1:0] clear,
  output logic [W-1:0] req
);
  logic [W-1:0] held;

  for (genvar b = 0; b < W; b++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) held[b] <= 1'b0;
      else     held[b] <= (held[b] | pulse[b]) & ~clear[b];
    end
    assign req[b] = held[b] | pulse[b];
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import ivu_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = DEF_PERIPH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  insn_boundary,
  input  logic                  i_mask,
  input  logic                  x_mask,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic [NUM_PERIPH-1:0] periph_en,
  input  logic [SCI_NFLAG-1:0]  sci_flags,
  input  logic [SCI_NEN-1:0]    sci_en,
  input  logic                  irq_req,
  input  logic                  xirq_req,
  input  logic                  swi_pulse,
  input  logic                  illop_pulse,
  input  logic                  cop_fail,
  input  logic                  cop_disable,
  input  logic                  clkmon_fail,
  input  logic                  clkmon_en,
  output logic                  pending,
  output logic                  take,
  output logic                  set_i,
  output logic                  set_x,
  output logic [VEC_W-1:0]      vector_addr
);
  localparam int unsigned NUM_SRC   = NUM_PERIPH + 7;
  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam int unsigned XIRQ_IDX  = NUM_PERIPH + 2;
  localparam int unsigned SWI_IDX   = NUM_PERIPH + 3;
  localparam int unsigned ILLOP_IDX = NUM_PERIPH + 4;

  logic [NUM_SRC-1:0]  live;
  logic [NUM_TRAP-1:0] trap_req;
  logic [NUM_TRAP-1:0] trap_clr;
  logic                win_valid;
  logic [IDX_W-1:0]    win_idx;
  logic                do_take;
  logic [VEC_W-1:0]    win_vec;

  ivu_trap_latch #(.W(NUM_TRAP)) u_traps (
    .clk   (clk),
    .rst   (rst),
    .pulse ({illop_pulse, swi_pulse}),
    .clear (trap_clr),
    .req   (trap_req)
  );

  ivu_req_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
    .periph_req  (periph_req),
    .periph_en   (periph_en),
    .sci_flags   (sci_flags),
    .sci_en      (sci_en),
    .irq_req     (irq_req),
    .xirq_req    (xirq_req),
    .swi_req     (trap_req[TRAP_SWI]),
    .illop_req   (trap_req[TRAP_ILLOP]),
    .cop_fail    (cop_fail),
    .cop_disable (cop_disable),
    .clkmon_fail (clkmon_fail),
    .clkmon_en   (clkmon_en),
    .i_mask      (i_mask),
    .x_mask      (x_mask),
    .live        (live)
  );

  ivu_prio_enc #(.N(NUM_SRC)) u_prio (
    .req   (live),
    .valid (win_valid),
    .idx   (win_idx)
  );

  assign pending = win_valid;
  assign do_take = insn_boundary & win_valid & ~rst;
  assign win_vec = VEC_BASE + ({{(VEC_W-IDX_W){1'b0}}, win_idx} << 1);

  assign trap_clr[TRAP_SWI]   = do_take && (win_idx == IDX_W'(SWI_IDX));
  assign trap_clr[TRAP_ILLOP] = do_take && (win_idx == IDX_W'(ILLOP_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      take        <= 1'b0;
      set_i       <= 1'b0;
      set_x       <= 1'b0;
      vector_addr <= RESET_VEC;
    end else begin
      take  <= do_take;
      set_i <= do_take;
      set_x <= do_take && (win_idx == IDX_W'(XIRQ_IDX));
      if (do_take) vector_addr <= win_vec;
    end
  end
endmodule

// File: rtl/ivu_checker.sv
module ivu_checker
  import ivu_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             insn_boundary,
  input logic             i_mask,
  input logic             pending,
  input logic             take,
  input logic             set_i,
  input logic             set_x,
  input logic [VEC_W-1:0] vector_addr
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (vector_addr == RESET_VEC && !take && !set_i && !set_x));

  p_take_after_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(insn_boundary));

  p_boundary_serviced_r11: assert property (@(posedge clk) disable iff (rst)
    (insn_boundary && pending) |=> take);

  p_hold_vector_r9: assert property (@(posedge clk) disable iff (rst)
    !take |-> $stable(vector_addr));

  p_set_i_with_take_r10: assert property (@(posedge clk) disable iff (rst)
    take |-> set_i);

  p_set_x_only_xirq_r10: assert property (@(posedge clk) disable iff (rst)
    set_x |-> (take && vector_addr == 16'hFFF4));

  p_i_mask_blocks_low_r3: assert property (@(posedge clk) disable iff (rst)
    (take && $past(i_mask)) |-> vector_addr >= 16'hFFF4);

  p_legal_range_r13: assert property (@(posedge clk) disable iff (rst)
    take |-> (vector_addr >= VEC_BASE && vector_addr <= 16'hFFFC && !vector_addr[0]));
endmodule

bind irq_vector_unit ivu_checker i_ivu_checker (
  .clk           (clk),
  .rst           (rst),
  .insn_boundary (insn_boundary),
  .i_mask        (i_mask),
  .pending       (pending),
  .take          (take),
  .set_i         (set_i),
  .set_x         (set_x),
  .vector_addr   (vector_addr)
);

// File: tb/test_irq_vector_unit.sv
module test_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_boundary = 1'b0;
  logic        i_mask = 1'b0, x_mask = 1'b0;
  logic [12:0] periph_req = '0, periph_en = '0;
  logic [4:0]  sci_flags = '0;
  logic [3:0]  sci_en = '0;
  logic        irq_req = 1'b0, xirq_req = 1'b0;
  logic        swi_pulse = 1'b0, illop_pulse = 1'b0;
  logic        cop_fail = 1'b0, cop_disable = 1'b0;
  logic        clkmon_fail = 1'b0, clkmon_en = 1'b0;
  logic        pending, take, set_i, set_x;
  logic [15:0] vector_addr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] last_vec = 16'hFFFE;

  typedef struct {
    logic        tk;
    logic [15:0] v;
    logic        sx;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  irq_vector_unit i_irq_vector_unit (
    .clk(clk), .rst(rst), .insn_boundary(insn_boundary),
    .i_mask(i_mask), .x_mask(x_mask),
    .periph_req(periph_req), .periph_en(periph_en),
    .sci_flags(sci_flags), .sci_en(sci_en),
    .irq_req(irq_req), .xirq_req(xirq_req),
    .swi_pulse(swi_pulse), .illop_pulse(illop_pulse),
    .cop_fail(cop_fail), .cop_disable(cop_disable),
    .clkmon_fail(clkmon_fail), .clkmon_en(clkmon_en),
    .pending(pending), .take(take), .set_i(set_i), .set_x(set_x),
    .vector_addr(vector_addr)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    i_mask = 0; x_mask = 0; periph_req = '0; periph_en = '0;
    sci_flags = '0; sci_en = '0; irq_req = 0; xirq_req = 0;
    swi_pulse = 0; illop_pulse = 0; cop_fail = 0; cop_disable = 0;
    clkmon_fail = 0; clkmon_en = 0;
  endtask

  task automatic chk_pending(input logic e, input string tag);
    #1;
    check(pending === e, tag, {15'd0, pending}, {15'd0, e});
  endtask

  // driver: strobe (or not) for one cycle and queue the expected outcome
  task automatic step(input logic bnd, input logic tk, input logic [15:0] v, input logic sx, input string tag);
    exp_t e;
    insn_boundary = bnd;
    if (tk) last_vec = v;
    e.tk = tk; e.v = tk ? v : last_vec; e.sx = sx; e.due = cyc + 1; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    insn_boundary = 0;
    swi_pulse = 0;
    illop_pulse = 0;
  endtask

  task automatic step_take(input logic [15:0] v, input logic sx, input string tag);
    step(1'b1, 1'b1, v, sx, tag);
  endtask

  task automatic step_none(input string tag);
    step(1'b1, 1'b0, 16'h0, 1'b0, tag);
  endtask

  // monitor: compare queued expectations in the cycle they fall due
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(take === e.tk, {e.tag, " take"}, {15'd0, take}, {15'd0, e.tk});
        check(set_i === e.tk, {e.tag, " set_i"}, {15'd0, set_i}, {15'd0, e.tk});
        check(set_x === e.sx, {e.tag, " set_x"}, {15'd0, set_x}, {15'd0, e.sx});
        check(vector_addr === e.v, {e.tag, " vector"}, vector_addr, e.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: requests and strobe during reset give nothing
    irq_req = 1; insn_boundary = 1;
    repeat (3) @(negedge clk);
    check(vector_addr === 16'hFFFE, "R1 reset vector", vector_addr, 16'hFFFE);
    check(!take && !set_i && !set_x, "R1 reset strobes", {13'd0, take, set_i, set_x}, 16'h0);
    insn_boundary = 0; clear_inputs();
    rst = 0;
    @(negedge clk);
    check(vector_addr === 16'hFFFE && !take, "R1 after reset", vector_addr, 16'hFFFE);

    // R9 R11: nothing pending
    chk_pending(0, "R11 idle");
    step_none("R9 no request");

    // R6: local enable
    periph_req[0] = 1;
    chk_pending(0, "R6 disabled spi");
    step_none("R6 disabled spi");
    periph_en[0] = 1;
    chk_pending(1, "R11 spi pending");
    step_take(16'hFFD8, 0, "R6 enabled spi");

    // R2: each peripheral slot
    for (int k = 0; k < 13; k++) begin
      clear_inputs();
      periph_req[k] = 1; periph_en[k] = 1;
      step_take(16'hFFD8 + 16'(2 * k), 0, "R2 periph slot");
    end

    // R7: SCI flag to enable mapping
    for (int f = 0; f < 5; f++) begin
      clear_inputs();
      sci_flags[f] = 1;
      sci_en[(f == 4) ? 3 : f] = 1;
      step_take(16'hFFD6, 0, "R7 sci flag");
    end
    clear_inputs(); sci_flags = 5'b10000; sci_en = 4'b0111;
    step_none("R7 rx full wrong enable");
    clear_inputs(); sci_flags = 5'b01000; sci_en = 4'b0111;
    step_none("R7 overrun wrong enable");

    // R2: priority among competitors
    clear_inputs();
    sci_flags[0] = 1; sci_en[0] = 1; periph_req[12] = 1; periph_en[12] = 1; irq_req = 1;
    step_take(16'hFFF2, 0, "R2 irq beats rti");
    irq_req = 0;
    step_take(16'hFFF0, 0, "R2 rti beats sci");

    // R3 R4 R10: I mask
    clear_inputs();
    i_mask = 1; irq_req = 1; periph_req[3] = 1; periph_en[3] = 1;
    chk_pending(0, "R3 i mask pending");
    step_none("R3 i mask blocks");
    xirq_req = 1;
    chk_pending(1, "R4 xirq under i mask");
    step_take(16'hFFF4, 1, "R4 R10 xirq");

    // R4 R10: X mask
    clear_inputs();
    x_mask = 1; xirq_req = 1;
    step_none("R4 x mask blocks");
    irq_req = 1;
    step_take(16'hFFF2, 0, "R10 irq no set_x");

    // R5 R8: traps ignore masks, own gates
    clear_inputs();
    i_mask = 1; x_mask = 1; cop_fail = 1;
    step_take(16'hFFFA, 0, "R5 cop");
    cop_disable = 1;
    step_none("R8 cop disabled");
    clkmon_fail = 1;
    step_none("R8 clkmon disabled");
    clkmon_en = 1;
    step_take(16'hFFFC, 0, "R5 clkmon");
    cop_disable = 0;
    step_take(16'hFFFC, 0, "R2 R13 clkmon over cop");

    // R9: no boundary, no take
    clear_inputs();
    irq_req = 1;
    step(1'b0, 1'b0, 16'h0, 1'b0, "R9 no boundary");
    step_take(16'hFFF2, 0, "R9 boundary takes");

    // R12: trap latching
    clear_inputs();
    i_mask = 1; x_mask = 1;
    swi_pulse = 1;
    @(negedge clk);
    swi_pulse = 0;
    repeat (2) @(negedge clk);
    chk_pending(1, "R12 swi held");
    step_take(16'hFFF6, 0, "R12 R5 swi");
    chk_pending(0, "R12 swi cleared");
    step_none("R12 single take");
    swi_pulse = 1; illop_pulse = 1;
    @(negedge clk);
    swi_pulse = 0; illop_pulse = 0;
    step_take(16'hFFF8, 0, "R12 illop first");
    step_take(16'hFFF6, 0, "R12 swi second");
    step_none("R12 both cleared");
    swi_pulse = 1;
    step_take(16'hFFF6, 0, "R12 pulse at boundary");
    step_none("R12 pulse at boundary once");

    // R1: reset mid-run
    repeat (2) @(negedge clk);
    rst = 1; irq_req = 1; insn_boundary = 1;
    @(negedge clk);
    @(negedge clk);
    check(vector_addr === 16'hFFFE, "R1 mid reset vector", vector_addr, 16'hFFFE);
    check(!take, "R1 mid reset take", {15'd0, take}, 16'h0);
    insn_boundary = 0; rst = 0; clear_inputs();

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule